// File: doc/BRIEF.md
# Mode-Switchable Policy FIFO

This block is a small first-in first-out buffer of 16-bit words placed between on-chip data producers and the register port of a serial host interface. A 2-bit mode input selects the depth of the buffer and what happens when a word arrives while the buffer is full. In message mode it is an eight-word queue that refuses words it has no room for. In monitoring mode it is a seven-word window that always keeps the newest results. Each of those entries packs a 4-bit channel tag with a 12-bit conversion result. In streaming mode the host fills an eight-word buffer that a memory-programming consumer drains, and words written while it is full are dropped.

All modes share one storage array and one pair of pointers. The pointers wrap at the depth of the active mode. Changing the mode empties the buffer. Reads use a pop request: the popped word appears on a registered output after the clock edge. A pop on an empty buffer returns zero and raises a one-cycle underflow pulse.

Top module: `modal_fifo`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, rd_data is 0 and underflow is 0.
- R2: In every mode, popped words leave in the order they were accepted. The popped word is on rd_data in the cycle after the pop edge, and rd_data holds its value until the next pop.
- R3: With mode 2'b00 (message; 2'b11 acts the same), full rises at 8 stored words. A push while full, without a pop in the same cycle, is refused: count and the stored words are unchanged.
- R4: With mode 2'b01 (monitoring), full rises at 7 stored words.
- R5: In monitoring mode, a push while full, without a pop, discards the oldest word and stores the new one. Count stays at 7, so the buffer then holds the 7 most recent pushes.
- R6: In monitoring mode, a stored word is wr_tag in bits [15:12] and wr_data[11:0] in bits [11:0]. In the other modes, the stored word is wr_data unchanged.
- R7: With mode 2'b10 (streaming), full rises at 8 stored words, and a push while full, without a pop, is ignored.
- R8: On any clock edge where mode differs from its value at the previous edge, the buffer is emptied (count 0), and push and pop in that cycle have no effect.
- R9: A pop while empty leaves count unchanged, loads rd_data with 0 and raises underflow for exactly the following cycle.
- R10: In message or streaming mode, a push together with a pop while full are both accepted, and count stays at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy select: 00 message, 01 monitoring, 10 streaming, 11 message |
| push | input | 1 | Write request |
| wr_data | input | 16 | Write word; only bits [11:0] are used in monitoring mode |
| wr_tag | input | 4 | Channel tag stored with the word in monitoring mode |
| pop | input | 1 | Read request |
| rd_data | output | 16 | Last popped word (0 after an empty pop) |
| count | output | 4 | Number of stored words |
| full | output | 1 | Count equals the active mode's depth |
| empty | output | 1 | Count is zero |
| underflow | output | 1 | One-cycle pulse after a pop on an empty buffer |

## Verification
A push and a pop can land on the same edge while the buffer is full. When that happens, the outcome depends on the mode: in monitoring mode, an overwrite must not also be applied, and in the other modes the push must not be refused. The bench fills the buffer to its depth in each mode and then drives push and pop together. A queue model applies the policy of the active mode and predicts the count and the word that leaves. The same model covers the pop-while-empty corner, where a push in the same cycle must still land.

// File: rtl/modal_fifo_pkg.sv
package modal_fifo_pkg;

   typedef enum logic [1:0] {
      MODE_MSG = 2'b00,
      MODE_MON = 2'b01,
      MODE_STR = 2'b10,
      MODE_ALT = 2'b11
   } fifo_mode_e;

endpackage

// File: rtl/modal_fifo_store.sv
module modal_fifo_store #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [W-1:0]     wr_word,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [W-1:0]     rd_word
);

   logic [W-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(i)) q <= wr_word;
      end
      assign cells[i] = q;
   end

   assign rd_word = cells[rd_idx];

endmodule

// File: rtl/modal_fifo_ctrl.sv
module modal_fifo_ctrl
   import modal_fifo_pkg::*;
#(
   parameter int unsigned STORE_DEPTH = 8,
   parameter int unsigned MSG_DEPTH   = 8,
   parameter int unsigned MON_DEPTH   = 7,
   parameter int unsigned STR_DEPTH   = 8,
   localparam int unsigned PTR_W = $clog2(STORE_DEPTH),
   localparam int unsigned CNT_W = $clog2(STORE_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             push,
   input  logic             pop,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic             rd_en,
   output logic             rd_zero,
   output logic [PTR_W-1:0] rd_idx,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic             underflow
);

   logic [1:0]       mode_q;
   logic             flush;
   logic [CNT_W-1:0] depth_now;
   logic [PTR_W-1:0] last_idx;
   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic             evict;

   always_comb begin
      case (fifo_mode_e'(mode_q))
         MODE_MON: depth_now = CNT_W'(MON_DEPTH);
         MODE_STR: depth_now = CNT_W'(STR_DEPTH);
         default:  depth_now = CNT_W'(MSG_DEPTH);
      endcase
   end

   assign last_idx = PTR_W'(depth_now - 1'b1);
   assign wr_nxt   = (wr_idx == last_idx) ? '0 : wr_idx + 1'b1;
   assign rd_nxt   = (rd_idx == last_idx) ? '0 : rd_idx + 1'b1;

   assign flush   = (mode != mode_q);
   assign full    = (count == depth_now);
   assign empty   = (count == '0);
   assign rd_en   = pop && !empty && !flush;
   assign rd_zero = pop && empty && !flush;
   assign wr_en   = push && !flush &&
                    (!full || rd_en || fifo_mode_e'(mode_q) == MODE_MON);
   assign evict   = wr_en && full && !rd_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_MSG;
         wr_idx    <= '0;
         rd_idx    <= '0;
         count     <= '0;
         underflow <= 1'b0;
      end else begin
         mode_q <= mode;
         if (flush) begin
            wr_idx    <= '0;
            rd_idx    <= '0;
            count     <= '0;
            underflow <= 1'b0;
         end else begin
            underflow <= rd_zero;
            if (wr_en) wr_idx <= wr_nxt;
            if (rd_en || evict) rd_idx <= rd_nxt;
            if (wr_en && !evict && !rd_en) count <= count + 1'b1;
            else if (rd_en && !wr_en) count <= count - 1'b1;
         end
      end
   end

endmodule

// File: rtl/modal_fifo.sv
module modal_fifo
   import modal_fifo_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TAG_W       = 4,
   parameter int unsigned STORE_DEPTH = 8,
   parameter int unsigned MSG_DEPTH   = 8,
   parameter int unsigned MON_DEPTH   = 7,
   parameter int unsigned STR_DEPTH   = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [1:0]                       mode,
   input  logic                             push,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic [TAG_W-1:0]                 wr_tag,
   input  logic                             pop,
   output logic [DATA_W-1:0]                rd_data,
   output logic [$clog2(STORE_DEPTH+1)-1:0] count,
   output logic                             full,
   output logic                             empty,
   output logic                             underflow
);

   localparam int unsigned PTR_W = $clog2(STORE_DEPTH);
   localparam int unsigned RES_W = DATA_W - TAG_W;

   initial begin : p_param_chk
      assert (STORE_DEPTH >= 2)
         else $error("modal_fifo: STORE_DEPTH must be at least 2");
      assert (MSG_DEPTH >= 1 && MSG_DEPTH <= STORE_DEPTH)
         else $error("modal_fifo: MSG_DEPTH out of range");
      assert (MON_DEPTH >= 1 && MON_DEPTH <= STORE_DEPTH)
         else $error("modal_fifo: MON_DEPTH out of range");
      assert (STR_DEPTH >= 1 && STR_DEPTH <= STORE_DEPTH)
         else $error("modal_fifo: STR_DEPTH out of range");
      assert (TAG_W < DATA_W)
         else $error("modal_fifo: TAG_W must be narrower than DATA_W");
   end

   logic              wr_en, rd_en, rd_zero;
   logic [PTR_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] entry_in, head_word, mon_word;

   generate
      if (TAG_W > 0) begin : g_tagged
         assign mon_word = {wr_tag, wr_data[RES_W-1:0]};
      end else begin : g_plain
         logic unused_tag;
         assign unused_tag = ^wr_tag;
         assign mon_word   = wr_data;
      end
   endgenerate

   assign entry_in = (fifo_mode_e'(mode) == MODE_MON) ? mon_word : wr_data;

   modal_fifo_ctrl #(
      .STORE_DEPTH (STORE_DEPTH),
      .MSG_DEPTH   (MSG_DEPTH),
      .MON_DEPTH   (MON_DEPTH),
      .STR_DEPTH   (STR_DEPTH)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .push      (push),
      .pop       (pop),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .rd_en     (rd_en),
      .rd_zero   (rd_zero),
      .rd_idx    (rd_idx),
      .count     (count),
      .full      (full),
      .empty     (empty),
      .underflow (underflow)
   );

   modal_fifo_store #(
      .W     (DATA_W),
      .DEPTH (STORE_DEPTH)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_word (entry_in),
      .rd_idx  (rd_idx),
      .rd_word (head_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_data <= '0;
      else if (rd_en)   rd_data <= head_word;
      else if (rd_zero) rd_data <= '0;
   end

endmodule

// File: rtl/modal_fifo_chk.sv
module modal_fifo_chk #(
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned MSG_DEPTH = 8,
   parameter int unsigned MON_DEPTH = 7,
   parameter int unsigned STR_DEPTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             push,
   input logic             pop,
   input logic [CNT_W-1:0] count,
   input logic             full,
   input logic             empty,
   input logic             underflow
);

   AST_RESET_FLAGS: assert property (@(posedge clk) !(full && empty)); // R1

   AST_MON_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && $stable(mode)) |-> count <= CNT_W'(MON_DEPTH)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b01 && $stable(mode) && full && push && !pop)
      |=> count == $past(count)); // R3

   AST_MON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && $stable(mode) && full && push && !pop)
      |=> (full && count == CNT_W'(MON_DEPTH))); // R5

   AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |=> (count == '0 && empty)); // R8

   AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && $stable(mode)) |=> underflow); // R9

   AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> $past(pop && empty)); // R9

   AST_PUSHPOP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b01 && $stable(mode) && full && push && pop)
      |=> count == $past(count)); // R10

   AST_STR_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && $stable(mode)) |-> count <= CNT_W'(STR_DEPTH)); // R7

   AST_MSG_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[0] == mode[1] && $stable(mode)) |-> count <= CNT_W'(MSG_DEPTH)); // R3

endmodule

bind modal_fifo modal_fifo_chk #(
   .CNT_W     ($clog2(STORE_DEPTH + 1)),
   .MSG_DEPTH (MSG_DEPTH),
   .MON_DEPTH (MON_DEPTH),
   .STR_DEPTH (STR_DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .push      (push),
   .pop       (pop),
   .count     (count),
   .full      (full),
   .empty     (empty),
   .underflow (underflow)
);

// File: tb/sim_modal_fifo.sv
`timescale 1ns/100ps
module sim_modal_fifo;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        push = 1'b0;
   logic        pop = 1'b0;
   logic [15:0] wr_data = '0;
   logic [3:0]  wr_tag = '0;
   logic [15:0] rd_data;
   logic [3:0]  count;
   logic        full, empty, underflow;

   modal_fifo u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .push(push), .wr_data(wr_data),
      .wr_tag(wr_tag), .pop(pop), .rd_data(rd_data), .count(count),
      .full(full), .empty(empty), .underflow(underflow)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      string       req;
      logic [15:0] rd;
      logic        uf;
      int          cnt;
      logic        fl;
      logic        em;
   } exp_t;

   exp_t        exp_q[$];
   logic [15:0] model_q[$];
   logic [1:0]  mmode = 2'b00;
   logic [15:0] last_rd = '0;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          finished = 0;

   function automatic int dep(logic [1:0] m);
      return (m == 2'b01) ? 7 : 8;
   endfunction

   task automatic check(string req, string what, int act, int expv);
      n_vec++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the predicted result
   task automatic cyc(bit ps, bit pp, logic [15:0] d, logic [3:0] t,
                      logic [1:0] m, string req);
      exp_t e;
      bit   pop_ok, full0, push_ok;
      mode = m; push = ps; pop = pp; wr_data = d; wr_tag = t;
      e.uf = 1'b0;
      if (m != mmode) begin
         model_q.delete();
         mmode = m;
      end else begin
         pop_ok  = pp && model_q.size() > 0;
         e.uf    = pp && model_q.size() == 0;
         full0   = model_q.size() == dep(m);
         push_ok = ps && (!full0 || pop_ok || m == 2'b01);
         if (pp) last_rd = pop_ok ? model_q[0] : 16'h0000;
         if (pop_ok) void'(model_q.pop_front());
         if (push_ok) begin
            if (model_q.size() == dep(m)) void'(model_q.pop_front());
            model_q.push_back((m == 2'b01) ? {t, d[11:0]} : d);
         end
      end
      e.rd  = last_rd;
      e.cnt = model_q.size();
      e.fl  = (e.cnt == dep(m));
      e.em  = (e.cnt == 0);
      e.req = req;
      exp_q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
   endtask

   // monitor: compares the design's outputs with the scoreboard after each edge
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         check(e.req, "count", int'(count), e.cnt);
         check(e.req, "full", int'(full), int'(e.fl));
         check(e.req, "empty", int'(empty), int'(e.em));
         check(e.req, "rd_data", int'(rd_data), int'(e.rd));
         check(e.req, "underflow", int'(underflow), int'(e.uf));
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "count", int'(count), 0);
      check("R1", "empty", int'(empty), 1);
      check("R1", "full", int'(full), 0);
      check("R1", "rd_data", int'(rd_data), 0);
      check("R1", "underflow", int'(underflow), 0);

      // R3 message fill to 8, then refused pushes; R2 order
      for (int i = 0; i < 8; i++) cyc(1, 0, 16'hA000 + 16'(i), 4'h0, 2'b00, "R3");
      cyc(1, 0, 16'hDEAD, 4'h0, 2'b00, "R3");
      cyc(1, 0, 16'hBEEF, 4'h0, 2'b00, "R3");
      // R10 push+pop while full
      cyc(1, 1, 16'hA100, 4'h0, 2'b00, "R10");
      cyc(1, 1, 16'hA101, 4'h0, 2'b00, "R10");
      for (int i = 0; i < 8; i++) cyc(0, 1, 16'h0, 4'h0, 2'b00, "R2");
      // R9 empty pop, pulse lasts one cycle, then pop-empty with push
      cyc(0, 1, 16'h0, 4'h0, 2'b00, "R9");
      cyc(0, 0, 16'h0, 4'h0, 2'b00, "R9");
      cyc(1, 1, 16'h5A5A, 4'h0, 2'b00, "R9");
      cyc(0, 0, 16'h0, 4'h0, 2'b00, "R2");

      // R8 switch to monitoring with a push in the flush cycle
      cyc(1, 1, 16'h1111, 4'h3, 2'b01, "R8");
      // R4 R5 R6 monitoring fill then overwrite
      for (int i = 0; i < 10; i++)
         cyc(1, 0, 16'hF100 + 16'(i), 4'(i + 1), 2'b01, (i < 7) ? "R4" : "R5");
      cyc(1, 1, 16'hE2AB, 4'hC, 2'b01, "R5");
      for (int i = 0; i < 7; i++) cyc(0, 1, 16'h0, 4'h0, 2'b01, "R6");
      cyc(0, 1, 16'h0, 4'h0, 2'b01, "R9");

      // R7 streaming fill, drop, push+pop full, drain
      cyc(0, 0, 16'h0, 4'h0, 2'b10, "R8");
      for (int i = 0; i < 8; i++) cyc(1, 0, 16'h7700 + 16'(i), 4'hF, 2'b10, "R7");
      cyc(1, 0, 16'hBAD0, 4'h0, 2'b10, "R7");
      cyc(1, 1, 16'h7780, 4'h0, 2'b10, "R10");
      for (int i = 0; i < 8; i++) cyc(0, 1, 16'h0, 4'h0, 2'b10, "R2");

      // R8 flush with data present
      for (int i = 0; i < 3; i++) cyc(1, 0, 16'h3300 + 16'(i), 4'h0, 2'b10, "R7");
      cyc(0, 1, 16'h0, 4'h0, 2'b00, "R8");
      cyc(0, 1, 16'h0, 4'h0, 2'b00, "R8");

      // R3 alternate encoding acts as message
      cyc(0, 0, 16'h0, 4'h0, 2'b11, "R8");
      for (int i = 0; i < 9; i++) cyc(1, 0, 16'hC000 + 16'(i), 4'h0, 2'b11, "R3");
      for (int i = 0; i < 8; i++) cyc(0, 1, 16'h0, 4'h0, 2'b11, "R2");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule